// File: doc/BRIEF.md
# Processor Power Mode Controller

This block moves a processor core between three power modes: run, idle and sleep. Software raises a request to enter idle or sleep. A wake event, such as an interrupt, brings the core back. The block drives two enables. The clock-enable gates the core clock. The power-domain enable removes supply from most of the core's logic. It also reports the current mode as a 2-bit code, raises a busy flag while a change of mode is under way, and gives a fixed-point energy weight for the present state.

Every change of mode takes a fixed number of clock cycles, and the number depends on the two modes involved. A down-counter loads the latency of the chosen change and releases the new mode when it reaches zero. In idle only the clock is stopped. In sleep the power is also removed. Leaving sleep takes much longer than entering it. There is no direct path from sleep to idle: a wake always ends in run.

All pins are plain control and status signals, so there is no valid/ready handshake and no back-pressure. Each request and wake input is sampled on every rising clock edge, and its effect is decided there.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, the outputs read mode = 2'b00 (run), clk_en = 1, pwr_en = 1, busy = 0 and weight = the run weight.
- R2: The mode code is 2'b00 for run, 2'b01 for idle, 2'b10 for sleep and 2'b11 while a change is in progress. busy is 1 exactly when the code is 2'b11. In run, clk_en and pwr_en are both 1.
- R3: In idle, clk_en = 0 and pwr_en = 1.
- R4: In sleep, clk_en = 0 and pwr_en = 0.
- R5: busy stays high for the following number of consecutive cycles, beginning the cycle after the triggering edge:
  - LAT_SHORT for run to idle and for idle to run;
  - LAT_SLEEP_IN for run to sleep and for idle to sleep;
  - LAT_WAKE for sleep to run.
- R6: Request decoding:
  - In run, req_sleep takes priority over req_idle, and wake is ignored.
  - In idle, wake takes priority over req_sleep, and req_idle is ignored.
  - In sleep, req_idle and req_sleep are ignored.
- R7: A change that starts in sleep always ends in run. Sleep never leads directly to idle.
- R8: req_idle and req_sleep that arrive while busy is high are ignored. The change in progress ends in its original target, and no further change starts from them.
- R9: Wake events during a change:
  - A wake event seen while busy, during a change toward idle or sleep, is held. The target mode is shown for exactly one cycle, and then a change toward run begins.
  - A wake seen during a change toward run has no effect.
- R10: Order of the enables around sleep:
  - On a change into sleep, clk_en drops in the first busy cycle and pwr_en drops one cycle later.
  - On leaving sleep, pwr_en returns in the first busy cycle, and clk_en returns only when mode reads run.
- R11: weight is an unsigned fixed-point value with W_FRAC fractional bits, equal to round(hundredths × 2^W_FRAC / 100). With the default parameters this gives run = 102400 (400.0), idle = 12800 (50.0) and sleep = 41 (about 0.16). While busy, the run weight is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock (free-running) |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_idle | input | 1 | Software request to enter idle |
| req_sleep | input | 1 | Software request to enter sleep |
| wake | input | 1 | Wake event, returns the core to run |
| clk_en | output | 1 | Core clock enable |
| pwr_en | output | 1 | Core power-domain enable |
| mode | output | 2 | Current mode code |
| busy | output | 1 | High while a change of mode is in progress |
| weight | output | WEIGHT_W | Energy weight of the current state, fixed point |

## Verification
The bench builds the controller with latencies of 3, 5 and 8 cycles for the short, sleep-entry and wake changes, and keeps the default weights. These short latencies let a few thousand random cycles cover every pair of modes many times. They also cover wake events that land on the final busy cycle, and requests that collide with the one-cycle visit to a target mode that a held wake produces. Because the three latencies differ, a swapped latency shows up as a wrong busy length.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'b00,
    PM_IDLE  = 2'b01,
    PM_SLEEP = 2'b10,
    PM_TRANS = 2'b11
  } pm_mode_e;

  function automatic int fx_weight(input int centi, input int frac);
    return (centi * (2 ** frac) + 50) / 100;
  endfunction
endpackage

// File: rtl/pmc_timer.sv
module pmc_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
#(
  parameter int LAT_SHORT    = 10,
  parameter int LAT_SLEEP_IN = 90,
  parameter int LAT_WAKE     = 160,
  parameter int CNT_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_idle,
  input  logic             req_sleep,
  input  logic             wake,
  input  logic             tmr_zero,
  output pm_mode_e         state_q,
  output pm_mode_e         tgt_q,
  output logic             first_q,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);
  localparam logic [CNT_W-1:0] V_SHORT = CNT_W'(LAT_SHORT - 1);
  localparam logic [CNT_W-1:0] V_SLEEP = CNT_W'(LAT_SLEEP_IN - 1);
  localparam logic [CNT_W-1:0] V_WAKE  = CNT_W'(LAT_WAKE - 1);

  pm_mode_e state_d, tgt_d;
  logic     pend_q, wake_eff, wake_start;

  always_comb begin
    state_d    = state_q;
    tgt_d      = tgt_q;
    tmr_load   = 1'b0;
    tmr_val    = V_SHORT;
    wake_start = 1'b0;
    wake_eff   = wake | pend_q;
    case (state_q)
      PM_RUN: begin
        if (req_sleep) begin
          state_d = PM_TRANS; tgt_d = PM_SLEEP; tmr_load = 1'b1; tmr_val = V_SLEEP;
        end else if (req_idle) begin
          state_d = PM_TRANS; tgt_d = PM_IDLE;  tmr_load = 1'b1; tmr_val = V_SHORT;
        end
      end
      PM_IDLE: begin
        if (wake_eff) begin
          state_d = PM_TRANS; tgt_d = PM_RUN; tmr_load = 1'b1; tmr_val = V_SHORT;
          wake_start = 1'b1;
        end else if (req_sleep) begin
          state_d = PM_TRANS; tgt_d = PM_SLEEP; tmr_load = 1'b1; tmr_val = V_SLEEP;
        end
      end
      PM_SLEEP: begin
        if (wake_eff) begin
          state_d = PM_TRANS; tgt_d = PM_RUN; tmr_load = 1'b1; tmr_val = V_WAKE;
          wake_start = 1'b1;
        end
      end
      default: begin
        if (tmr_zero) state_d = tgt_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_RUN;
      tgt_q   <= PM_RUN;
      first_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      first_q <= tmr_load;
      if (wake_start)
        pend_q <= 1'b0;
      else if (state_q == PM_TRANS && wake && tgt_q != PM_RUN)
        pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pmc_outmap.sv
module pmc_outmap
  import pmc_pkg::*;
#(
  parameter int W_FRAC        = 8,
  parameter int WEIGHT_W      = 20,
  parameter int W_RUN_CENTI   = 40000,
  parameter int W_IDLE_CENTI  = 5000,
  parameter int W_SLEEP_CENTI = 16
) (
  input  pm_mode_e             state_q,
  input  pm_mode_e             tgt_q,
  input  logic                 first_q,
  output logic                 clk_en,
  output logic                 pwr_en,
  output logic [1:0]           mode,
  output logic                 busy,
  output logic [WEIGHT_W-1:0]  weight
);
  localparam logic [WEIGHT_W-1:0] WV_RUN   = WEIGHT_W'(fx_weight(W_RUN_CENTI, W_FRAC));
  localparam logic [WEIGHT_W-1:0] WV_IDLE  = WEIGHT_W'(fx_weight(W_IDLE_CENTI, W_FRAC));
  localparam logic [WEIGHT_W-1:0] WV_SLEEP = WEIGHT_W'(fx_weight(W_SLEEP_CENTI, W_FRAC));

  logic sleep_entry_late;

  assign sleep_entry_late = (state_q == PM_TRANS) && (tgt_q == PM_SLEEP) && !first_q;
  assign clk_en = (state_q == PM_RUN);
  assign pwr_en = !((state_q == PM_SLEEP) || sleep_entry_late);
  assign mode   = state_q;
  assign busy   = (state_q == PM_TRANS);

  always_comb begin
    case (state_q)
      PM_IDLE:  weight = WV_IDLE;
      PM_SLEEP: weight = WV_SLEEP;
      default:  weight = WV_RUN;
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int LAT_SHORT     = 10,
  parameter int LAT_SLEEP_IN  = 90,
  parameter int LAT_WAKE      = 160,
  parameter int W_FRAC        = 8,
  parameter int WEIGHT_W      = 20,
  parameter int W_RUN_CENTI   = 40000,
  parameter int W_IDLE_CENTI  = 5000,
  parameter int W_SLEEP_CENTI = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_idle,
  input  logic                req_sleep,
  input  logic                wake,
  output logic                clk_en,
  output logic                pwr_en,
  output logic [1:0]          mode,
  output logic                busy,
  output logic [WEIGHT_W-1:0] weight
);
  localparam int LAT_MAX0 = (LAT_SHORT > LAT_SLEEP_IN) ? LAT_SHORT : LAT_SLEEP_IN;
  localparam int LAT_MAX  = (LAT_MAX0 > LAT_WAKE) ? LAT_MAX0 : LAT_WAKE;
  localparam int CNT_W    = (LAT_MAX < 2) ? 1 : $clog2(LAT_MAX);

  pm_mode_e         state_q, tgt_q;
  logic             first_q, tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;

  pmc_seq #(
    .LAT_SHORT(LAT_SHORT), .LAT_SLEEP_IN(LAT_SLEEP_IN), .LAT_WAKE(LAT_WAKE), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_idle(req_idle), .req_sleep(req_sleep), .wake(wake),
    .tmr_zero(tmr_zero), .state_q(state_q), .tgt_q(tgt_q), .first_q(first_q),
    .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  pmc_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  pmc_outmap #(
    .W_FRAC(W_FRAC), .WEIGHT_W(WEIGHT_W), .W_RUN_CENTI(W_RUN_CENTI),
    .W_IDLE_CENTI(W_IDLE_CENTI), .W_SLEEP_CENTI(W_SLEEP_CENTI)
  ) u_out (
    .state_q(state_q), .tgt_q(tgt_q), .first_q(first_q), .clk_en(clk_en), .pwr_en(pwr_en),
    .mode(mode), .busy(busy), .weight(weight)
  );
endmodule

// File: rtl/pmc_checks.sv
module pmc_checks #(
  parameter int LAT_SHORT     = 10,
  parameter int LAT_SLEEP_IN  = 90,
  parameter int LAT_WAKE      = 160,
  parameter int W_FRAC        = 8,
  parameter int WEIGHT_W      = 20,
  parameter int W_RUN_CENTI   = 40000,
  parameter int W_IDLE_CENTI  = 5000,
  parameter int W_SLEEP_CENTI = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                clk_en,
  input logic                pwr_en,
  input logic [1:0]          mode,
  input logic                busy,
  input logic [WEIGHT_W-1:0] weight
);
  localparam int LMAX = LAT_WAKE + LAT_SLEEP_IN + LAT_SHORT;
  localparam int CW   = $clog2(LMAX + 2);
  localparam logic [WEIGHT_W-1:0] CW_IDLE  = WEIGHT_W'((W_IDLE_CENTI * (2 ** W_FRAC) + 50) / 100);
  localparam logic [WEIGHT_W-1:0] CW_SLEEP = WEIGHT_W'((W_SLEEP_CENTI * (2 ** W_FRAC) + 50) / 100);

  logic          busy_d;
  logic [1:0]    mode_d, src_q;
  logic [CW-1:0] len_q, lat_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_d <= 1'b0; mode_d <= 2'b00; src_q <= 2'b00; len_q <= '0;
    end else begin
      busy_d <= busy;
      mode_d <= mode;
      if (busy && !busy_d) src_q <= mode_d;
      len_q <= busy ? len_q + 1'b1 : '0;
    end
  end

  always_comb begin
    if (mode == 2'b10)       lat_exp = CW'(LAT_SLEEP_IN);
    else if (src_q == 2'b10) lat_exp = CW'(LAT_WAKE);
    else                     lat_exp = CW'(LAT_SHORT);
  end

  p_busy_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) == busy);
  p_run_enables_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> (clk_en && pwr_en));
  p_idle_powered_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (pwr_en && !clk_en));
  p_sleep_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> (!pwr_en && !clk_en));
  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_d && !busy) |-> (len_q == lat_exp));
  p_sleep_exit_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_d && !busy && src_q == 2'b10) |-> (mode == 2'b00));
  p_pwr_after_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> (!clk_en && !$past(clk_en)));
  p_clk_after_pwr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> $past(pwr_en));
  p_weight_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (weight == CW_IDLE));
  p_weight_sleep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> (weight == CW_SLEEP));
endmodule

bind pwr_mode_ctrl pmc_checks #(
  .LAT_SHORT(LAT_SHORT), .LAT_SLEEP_IN(LAT_SLEEP_IN), .LAT_WAKE(LAT_WAKE),
  .W_FRAC(W_FRAC), .WEIGHT_W(WEIGHT_W), .W_RUN_CENTI(W_RUN_CENTI),
  .W_IDLE_CENTI(W_IDLE_CENTI), .W_SLEEP_CENTI(W_SLEEP_CENTI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .pwr_en(pwr_en),
  .mode(mode), .busy(busy), .weight(weight)
);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;
  localparam int L1 = 3, LS = 5, LW = 8, FR = 8, WW = 20;

  logic clk = 1'b0, rst_n = 1'b0, req_idle = 1'b0, req_sleep = 1'b0, wake = 1'b0;
  logic clk_en, pwr_en, busy;
  logic [1:0] mode;
  logic [WW-1:0] weight;

  int checks = 0, errors = 0;
  string tag = "R1";
  int m_st, m_tgt, m_cnt;
  bit m_first, m_pend, obs_busy;
  int obs_mode;

  pwr_mode_ctrl #(.LAT_SHORT(L1), .LAT_SLEEP_IN(LS), .LAT_WAKE(LW), .W_FRAC(FR), .WEIGHT_W(WW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_idle(req_idle), .req_sleep(req_sleep), .wake(wake),
    .clk_en(clk_en), .pwr_en(pwr_en), .mode(mode), .busy(busy), .weight(weight));

  always #2 clk = ~clk;

  function automatic int fxw(int centi);
    return (centi * (2 ** FR) + 50) / 100;
  endfunction

  function automatic int wexp(int st);
    if (st == 1) return fxw(5000);
    if (st == 2) return fxw(16);
    return fxw(40000);
  endfunction

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic compare();
    bit e_pwr;
    e_pwr = !(m_st == 2 || (m_st == 3 && m_tgt == 2 && !m_first));
    chk(int'(mode) == m_st, tag, "mode", int'(mode), m_st);
    chk(busy == (m_st == 3), tag, "busy", int'(busy), int'(m_st == 3));
    chk(clk_en == (m_st == 0), tag, "clk_en", int'(clk_en), int'(m_st == 0));
    chk(pwr_en == e_pwr, tag, "pwr_en", int'(pwr_en), int'(e_pwr));
    chk(int'(weight) == wexp(m_st), "R11", "weight", int'(weight), wexp(m_st));
    obs_busy = busy;
    obs_mode = int'(mode);
  endtask

  task automatic start(int tgt, int lat);
    m_st = 3; m_tgt = tgt; m_cnt = lat - 1; m_first = 1;
  endtask

  task automatic model_step(bit i, bit s, bit w);
    bit fired = 0;
    case (m_st)
      0: if (s) begin start(2, LS); fired = 1; end
         else if (i) begin start(1, L1); fired = 1; end
      1: if (w || m_pend) begin start(0, L1); m_pend = 0; fired = 1; end
         else if (s) begin start(2, LS); fired = 1; end
      2: if (w || m_pend) begin start(0, LW); m_pend = 0; fired = 1; end
      default: begin
        if (w && m_tgt != 0) m_pend = 1;
        if (m_cnt == 0) m_st = m_tgt; else m_cnt--;
      end
    endcase
    if (!fired) m_first = 0;
  endtask

  task automatic step(bit i, bit s, bit w);
    @(negedge clk);
    compare();
    req_idle = i; req_sleep = s; wake = w;
    model_step(i, s, w);
  endtask

  task automatic measure(bit i, bit s, bit w, int exp_lat, string rq);
    int n = 0;
    step(i, s, w);
    for (int k = 0; k < 100; k++) begin
      step(0, 0, 0);
      if (obs_busy) n++;
      else if (n > 0) break;
    end
    chk(n == exp_lat, rq, "busy length", n, exp_lat);
  endtask

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    m_st = 0; m_tgt = 0; m_cnt = 0; m_first = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    tag = "R1";
    compare();
    rst_n = 1'b1;
    step(0, 0, 0);
    // R5 / R3: run to idle
    tag = "R5"; measure(1, 0, 0, L1, "R5");
    tag = "R3"; step(0, 0, 0);
    chk(obs_mode == 1, "R3", "mode in idle", obs_mode, 1);
    // R6: req_idle ignored in idle, wake beats req_sleep
    tag = "R6"; step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);
    chk(obs_mode == 1, "R6", "idle holds on req_idle", obs_mode, 1);
    measure(0, 1, 1, L1, "R6");
    // R6 / R10: sleep beats idle from run, enable ordering checked each cycle
    tag = "R10"; measure(1, 1, 0, LS, "R10");
    tag = "R4"; step(1, 1, 0); step(0, 0, 0); step(0, 0, 0);
    chk(obs_mode == 2, "R4", "sleep holds on requests", obs_mode, 2);
    // R7: wake from sleep
    tag = "R7"; measure(0, 0, 1, LW, "R7");
    step(0, 0, 0);
    chk(obs_mode == 0, "R7", "sleep exit mode", obs_mode, 0);
    // R8: request during busy ignored
    tag = "R8"; step(1, 0, 0); step(0, 1, 0); step(0, 0, 0);
    repeat (L1 + 2) step(0, 0, 0);
    chk(obs_mode == 1, "R8", "target kept", obs_mode, 1);
    // R9: wake during change into sleep is held
    tag = "R9"; step(0, 1, 0); step(0, 0, 1);
    repeat (LS) step(0, 0, 0);
    chk(obs_mode == 2, "R9", "sleep visited", obs_mode, 2);
    step(0, 0, 0);
    chk(obs_busy == 1, "R9", "held wake starts change", int'(obs_busy), 1);
    step(0, 0, 1);
    repeat (LW + 2) step(0, 0, 0);
    chk(obs_mode == 0, "R9", "wake during run-bound change no effect", obs_mode, 0);
    // R2: constrained random
    tag = "R2";
    for (int c = 0; c < 4000; c++)
      step(($urandom % 100) < 10, ($urandom % 100) < 5, ($urandom % 100) < 8);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule